// File: doc/BRIEF.md
# Carry-Aware Rotate Unit

A 32-bit rotation engine for an integer execution pipeline. Each accepted request carries an operand, a shift count, a two-bit operation code and the present carry and overflow flags. The unit returns the rotated value together with updated carry and overflow flags one clock later. Two operations rotate the operand alone, left or right. The other two rotate a 33-bit quantity made of the carry flag on top of the operand, so the old carry enters the word and a bit of the operand leaves it as the new carry.

Only the low five bits of the count are used. A count whose low five bits are zero is a no-operation: the operand comes back unchanged and both flags are passed through as they were presented. Because of the masking, the 33-bit rotations never see a count of 32 or more, so no reduction modulo 33 is needed. The unit has no sign, zero, parity or half-carry outputs, because a rotate leaves those flags alone.

Top module: `carry_rotator`

## Requirements
- R1: `resValid` is high in exactly the cycles that follow a cycle with `reqValid` high. The result and flag outputs change only in the cycle after an accepted request and hold their value otherwise.
- R2: Only bits [4:0] of `rotCount` are used. Bits [7:5] have no effect, so a count of 33 acts as 1 and a count of 32 acts as 0.
- R3: When the masked count is zero, the result equals the operand, `carryOut` equals `carryIn` and `overflowOut` equals `overflowIn`.
- R4: With `opSel` = 0 (rotate left by n), bit i of the operand moves to bit (i+n) mod 32. Carry becomes result bit 0 and overflow becomes result bit 0 XOR result bit 31.
- R5: With `opSel` = 1 (rotate right by n), bit i of the operand moves to bit (i−n) mod 32. Carry becomes result bit 31 and overflow becomes result bit 31 XOR result bit 30.
- R6: With `opSel` = 2 (rotate left through carry by n), the 33-bit value {carry, operand} is rotated left by n. The old carry lands at result bit n−1, and the new carry is operand bit 32−n. Overflow is the new carry XOR result bit 31.
- R7: With `opSel` = 3 (rotate right through carry by n), the 33-bit value {carry, operand} is rotated right by n. The old carry lands at result bit 32−n, and the new carry is operand bit n−1. Overflow is result bit 31 XOR result bit 30.
- R8: While `rstN` is low and until the first accepted request, `resValid`, `result`, `carryOut` and `overflowOut` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Qualifies the request inputs in this cycle |
| operand | input | 32 | Value to rotate |
| rotCount | input | 8 | Rotate count; only bits [4:0] are used |
| opSel | input | 2 | 0 rotate left, 1 rotate right, 2 left through carry, 3 right through carry |
| carryIn | input | 1 | Current carry flag |
| overflowIn | input | 1 | Current overflow flag, returned when the count is zero |
| resValid | output | 1 | Result valid, one cycle after `reqValid` |
| result | output | 32 | Registered rotated value |
| carryOut | output | 1 | Registered new carry flag |
| overflowOut | output | 1 | Registered new overflow flag |

## Verification
The properties assume that while `reqValid` is high, the operand, count, operation code and flags are known values. They also assume that `rstN` is low long enough to clear the output registers. The bench drives every input from a defined value at each falling edge, including idle cycles, so no unknown value reaches a sampled request. All four operation codes, including the through-carry ones, are legal at any count, so the stimulus may use the full code and count ranges, upper count bits included. The bench runs directed corners first: counts of 0, 1, 2, 31, 32 and 33 with both carry values. It then runs a pseudo-random phase mixed with idle cycles.

// File: rtl/carry_rot_pkg.sv
package carry_rot_pkg;

  typedef enum logic [1:0] {
    OP_ROTL = 2'd0,
    OP_ROTR = 2'd1,
    OP_RCL  = 2'd2,
    OP_RCR  = 2'd3
  } rotOp_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;      // capture this cycle's request
    logic active;    // masked count is non-zero
    logic viaCarry;  // 33-bit rotation through carry
    logic toRight;   // rotate direction
  } rotCtrl_t;

endpackage

// File: rtl/carry_rot_ctrl.sv
module carry_rot_ctrl
  import carry_rot_pkg::*;
#(
  parameter int CNT_IN_W = 8,
  parameter int CNT_W    = 5
) (
  input  logic                reqValid,
  input  logic [CNT_IN_W-1:0] rotCount,
  input  logic [1:0]          opSel,
  output rotCtrl_t            ctrl,
  output logic [CNT_W-1:0]    effCount
);

  rotOp_e opCode;

  always_comb begin
    opCode        = rotOp_e'(opSel);
    effCount      = rotCount[CNT_W-1:0];
    ctrl.load     = reqValid;
    ctrl.active   = |effCount;
    ctrl.viaCarry = (opCode == OP_RCL) || (opCode == OP_RCR);
    ctrl.toRight  = (opCode == OP_ROTR) || (opCode == OP_RCR);
  end

endmodule

// File: rtl/carry_rot_datapath.sv
module carry_rot_datapath
  import carry_rot_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  rotCtrl_t          ctrl,
  input  logic [CNT_W-1:0]  effCount,
  input  logic [DATA_W-1:0] operand,
  input  logic              carryIn,
  input  logic              overflowIn,
  output logic              resValid,
  output logic [DATA_W-1:0] result,
  output logic              carryOut,
  output logic              overflowOut
);

  localparam int EXT_W = DATA_W + 1;
  localparam int AMT_W = CNT_W + 1;

  logic [AMT_W-1:0]  amt;
  logic [AMT_W-1:0]  plainComp;
  logic [AMT_W-1:0]  extComp;
  logic [DATA_W-1:0] plainL, plainR;
  logic [EXT_W-1:0]  ext, extL, extR;
  logic [DATA_W-1:0] nextRes;
  logic              nextCarry, nextOvf;

  // Complement amounts for the wrap-around half of each rotation
  always_comb begin
    amt       = {1'b0, effCount};
    plainComp = AMT_W'(DATA_W) - amt;
    extComp   = AMT_W'(EXT_W) - amt;
  end

  // Plain rotations over DATA_W bits
  always_comb begin
    plainL = (operand << amt) | (operand >> plainComp);
    plainR = (operand >> amt) | (operand << plainComp);
  end

  // Rotations of {carry, operand} over EXT_W bits
  always_comb begin
    ext  = {carryIn, operand};
    extL = (ext << amt) | (ext >> extComp);
    extR = (ext >> amt) | (ext << extComp);
  end

  // Result and flag selection
  always_comb begin
    nextRes   = operand;
    nextCarry = carryIn;
    nextOvf   = overflowIn;
    if (ctrl.active) begin
      unique case ({ctrl.viaCarry, ctrl.toRight})
        2'b00: begin
          nextRes   = plainL;
          nextCarry = plainL[0];
          nextOvf   = plainL[0] ^ plainL[DATA_W-1];
        end
        2'b01: begin
          nextRes   = plainR;
          nextCarry = plainR[DATA_W-1];
          nextOvf   = plainR[DATA_W-1] ^ plainR[DATA_W-2];
        end
        2'b10: begin
          nextRes   = extL[DATA_W-1:0];
          nextCarry = extL[DATA_W];
          nextOvf   = extL[DATA_W] ^ extL[DATA_W-1];
        end
        default: begin
          nextRes   = extR[DATA_W-1:0];
          nextCarry = extR[DATA_W];
          nextOvf   = extR[DATA_W-1] ^ extR[DATA_W-2];
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resValid    <= 1'b0;
      result      <= '0;
      carryOut    <= 1'b0;
      overflowOut <= 1'b0;
    end else begin
      resValid <= ctrl.load;
      if (ctrl.load) begin
        result      <= nextRes;
        carryOut    <= nextCarry;
        overflowOut <= nextOvf;
      end
    end
  end

endmodule

// File: rtl/carry_rotator.sv
module carry_rotator
  import carry_rot_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int CNT_IN_W = 8,
  parameter int CNT_W    = $clog2(DATA_W)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic [DATA_W-1:0]   operand,
  input  logic [CNT_IN_W-1:0] rotCount,
  input  logic [1:0]          opSel,
  input  logic                carryIn,
  input  logic                overflowIn,
  output logic                resValid,
  output logic [DATA_W-1:0]   result,
  output logic                carryOut,
  output logic                overflowOut
);

  rotCtrl_t         ctrl;
  logic [CNT_W-1:0] effCount;

  carry_rot_ctrl #(
    .CNT_IN_W(CNT_IN_W),
    .CNT_W   (CNT_W)
  ) ctrl_i (
    .reqValid(reqValid),
    .rotCount(rotCount),
    .opSel   (opSel),
    .ctrl    (ctrl),
    .effCount(effCount)
  );

  carry_rot_datapath #(
    .DATA_W(DATA_W),
    .CNT_W (CNT_W)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .effCount   (effCount),
    .operand    (operand),
    .carryIn    (carryIn),
    .overflowIn (overflowIn),
    .resValid   (resValid),
    .result     (result),
    .carryOut   (carryOut),
    .overflowOut(overflowOut)
  );

endmodule

// File: rtl/carry_rot_chk.sv
module carry_rot_chk #(
  parameter int DATA_W   = 32,
  parameter int CNT_IN_W = 8,
  parameter int CNT_W    = $clog2(DATA_W)
) (
  input logic                clk,
  input logic                rstN,
  input logic                reqValid,
  input logic [DATA_W-1:0]   operand,
  input logic [CNT_IN_W-1:0] rotCount,
  input logic [1:0]          opSel,
  input logic                carryIn,
  input logic                overflowIn,
  input logic                resValid,
  input logic [DATA_W-1:0]   result,
  input logic                carryOut,
  input logic                overflowOut
);

  logic cntZero;
  assign cntZero = (rotCount[CNT_W-1:0] == '0);

  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    resValid == $past(reqValid));

  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> $stable(result) && $stable(carryOut) && $stable(overflowOut));

  // R3
  zero_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && cntZero |=> result == $past(operand) && carryOut == $past(carryIn)
                            && overflowOut == $past(overflowIn));

  // R4
  rotl_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !cntZero && opSel == 2'd0 |=>
      carryOut == result[0] && overflowOut == (result[0] ^ result[DATA_W-1]));

  // R5
  rotr_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !cntZero && opSel == 2'd1 |=>
      carryOut == result[DATA_W-1] && overflowOut == (result[DATA_W-1] ^ result[DATA_W-2]));

  // R4
  rotl_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && opSel == 2'd0 |=> $countones(result) == $countones($past(operand)));

  // R5
  rotr_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && opSel == 2'd1 |=> $countones(result) == $countones($past(operand)));

  // R6
  rcl_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !cntZero && opSel == 2'd2 |=>
      overflowOut == (carryOut ^ result[DATA_W-1]));

  // R7
  rcr_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !cntZero && opSel == 2'd3 |=>
      overflowOut == (result[DATA_W-1] ^ result[DATA_W-2]));

  // R6
  rcl_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && opSel == 2'd2 |=>
      $countones({carryOut, result}) == $countones({$past(carryIn), $past(operand)}));

  // R7
  rcr_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && opSel == 2'd3 |=>
      $countones({carryOut, result}) == $countones({$past(carryIn), $past(operand)}));

  // R8
  always @(posedge clk) begin
    if (!rstN) begin
      reset_state_chk: assert (!resValid && result == '0 && !carryOut && !overflowOut);
    end
  end

endmodule

bind carry_rotator carry_rot_chk #(
  .DATA_W  (DATA_W),
  .CNT_IN_W(CNT_IN_W),
  .CNT_W   (CNT_W)
) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .operand    (operand),
  .rotCount   (rotCount),
  .opSel      (opSel),
  .carryIn    (carryIn),
  .overflowIn (overflowIn),
  .resValid   (resValid),
  .result     (result),
  .carryOut   (carryOut),
  .overflowOut(overflowOut)
);

// File: tb/carry_rotator_tb_top.sv
`timescale 1ns/1ps
module carry_rotator_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] operand = '0;
  logic [7:0]  rotCount = '0;
  logic [1:0]  opSel = '0;
  logic        carryIn = 1'b0;
  logic        overflowIn = 1'b0;
  logic        resValid;
  logic [31:0] result;
  logic        carryOut;
  logic        overflowOut;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic        expValid = 1'b0;
  logic [31:0] expRes = '0;
  logic        expC = 1'b0;
  logic        expO = 1'b0;

  always #2.5 clk = ~clk;

  carry_rotator dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .operand(operand),
    .rotCount(rotCount), .opSel(opSel), .carryIn(carryIn), .overflowIn(overflowIn),
    .resValid(resValid), .result(result), .carryOut(carryOut), .overflowOut(overflowOut)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Behavioural model: n single-bit steps
  task automatic model(input logic [31:0] op, input logic [7:0] cnt, input logic [1:0] sel,
                       input logic c, input logic o,
                       output logic [31:0] r, output logic rc, output logic ro);
    int n;
    logic cc;
    n  = int'(cnt % 8'd32);
    r  = op;
    cc = c;
    for (int k = 0; k < n; k++) begin
      case (sel)
        2'd0: r = {r[30:0], r[31]};
        2'd1: r = {r[0], r[31:1]};
        2'd2: begin logic t; t = r[31]; r = {r[30:0], cc}; cc = t; end
        default: begin logic t; t = r[0]; r = {cc, r[31:1]}; cc = t; end
      endcase
    end
    if (n == 0) begin
      rc = c; ro = o;
    end else begin
      case (sel)
        2'd0: begin rc = r[0];  ro = r[0] ^ r[31]; end
        2'd1: begin rc = r[31]; ro = r[31] ^ r[30]; end
        2'd2: begin rc = cc;    ro = cc ^ r[31]; end
        default: begin rc = cc; ro = r[31] ^ r[30]; end
      endcase
    end
  endtask

  function automatic string tagOf(input logic [7:0] cnt, input logic [1:0] sel);
    if (cnt[4:0] == 5'd0) return "R3";
    if (cnt[7:5] != 3'd0) return "R2";
    case (sel)
      2'd0: return "R4";
      2'd1: return "R5";
      2'd2: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic step(input logic v, input logic [31:0] op, input logic [7:0] cnt,
                      input logic [1:0] sel, input logic c, input logic o);
    string tag;
    reqValid = v; operand = op; rotCount = cnt; opSel = sel; carryIn = c; overflowIn = o;
    tag = v ? tagOf(cnt, sel) : "R1";
    @(posedge clk);
    if (v) model(op, cnt, sel, c, o, expRes, expC, expO);
    expValid = v;
    @(negedge clk);
    chk("R1", "valid", 32'(resValid), 32'(expValid));
    chk(tag, "result", result, expRes);
    chk(tag, "carry", 32'(carryOut), 32'(expC));
    chk(tag, "overflow", 32'(overflowOut), 32'(expO));
  endtask

  // Hand-computed corner expectations, checked after a step
  task automatic expectRes(input string req, input logic [31:0] r, input logic c, input logic o);
    chk(req, "corner result", result, r);
    chk(req, "corner carry", 32'(carryOut), 32'(c));
    chk(req, "corner overflow", 32'(overflowOut), 32'(o));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R8: reset state
    repeat (3) @(negedge clk);
    chk("R8", "reset valid", 32'(resValid), 32'd0);
    chk("R8", "reset result", result, 32'd0);
    chk("R8", "reset flags", {30'd0, carryOut, overflowOut}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R8", "post-reset idle", {29'd0, resValid, carryOut, overflowOut}, 32'd0);

    // R4 corner: 0x80000001 rotl 1 -> 0x00000003, c=1, o=1^0=1
    step(1, 32'h8000_0001, 8'd1, 2'd0, 1'b0, 1'b0);
    expectRes("R4", 32'h0000_0003, 1'b1, 1'b1);
    // R5 corner: 0x00000001 rotr 1 -> 0x80000000, c=1, o=1
    step(1, 32'h0000_0001, 8'd1, 2'd1, 1'b0, 1'b0);
    expectRes("R5", 32'h8000_0000, 1'b1, 1'b1);
    // R6 corner: 0x80000000 rcl 1 with c=1 -> 0x00000001, c=1, o=1^0=1
    step(1, 32'h8000_0000, 8'd1, 2'd2, 1'b1, 1'b0);
    expectRes("R6", 32'h0000_0001, 1'b1, 1'b1);
    // R6 corner: 0x00000001 rcl 31 c=0 -> old bit0 to bit31 ... carry = op bit1 = 0
    step(1, 32'h0000_0001, 8'd31, 2'd2, 1'b0, 1'b1);
    expectRes("R6", 32'h8000_0000, 1'b0, 1'b1);
    // R7 corner: 0x00000001 rcr 1 c=0 -> 0, c=1, o=0
    step(1, 32'h0000_0001, 8'd1, 2'd3, 1'b0, 1'b1);
    expectRes("R7", 32'h0000_0000, 1'b1, 1'b0);
    // R7 corner: 0 rcr 2 c=1 -> carry lands at bit 30: 0x40000000, c=0, o=1
    step(1, 32'h0000_0000, 8'd2, 2'd3, 1'b1, 1'b0);
    expectRes("R7", 32'h4000_0000, 1'b0, 1'b1);
    // R3: count zero passes flags through
    step(1, 32'hDEAD_BEEF, 8'd0, 2'd2, 1'b1, 1'b1);
    expectRes("R3", 32'hDEAD_BEEF, 1'b1, 1'b1);
    // R2: count 32 acts as zero, count 33 acts as one
    step(1, 32'h1234_5678, 8'd32, 2'd3, 1'b0, 1'b1);
    expectRes("R2", 32'h1234_5678, 1'b0, 1'b1);
    step(1, 32'h8000_0001, 8'd33, 2'd0, 1'b0, 1'b0);
    expectRes("R2", 32'h0000_0003, 1'b1, 1'b1);
    // R1: idle cycles hold outputs
    step(0, 32'hFFFF_FFFF, 8'd5, 2'd1, 1'b1, 1'b1);
    expectRes("R1", 32'h0000_0003, 1'b1, 1'b1);
    step(0, 32'h0, 8'd0, 2'd0, 1'b0, 1'b0);

    // Sweep all ops and counts with both carry values
    for (int s = 0; s < 4; s++) begin
      for (int n = 0; n < 34; n++) begin
        step(1, 32'hA5C3_0F96 ^ 32'(n * 32'h0101_0101), 8'(n), 2'(s), 1'(n), 1'(n >> 1));
      end
    end

    // Pseudo-random phase with idle gaps
    for (int i = 0; i < 600; i++) begin
      step(($urandom % 4) != 0, $urandom, 8'($urandom), 2'($urandom), 1'($urandom), 1'($urandom));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule